// File: doc/BRIEF.md
# Camera Link Packet Parser

This block sits on the receive side of a serial camera link, after the lanes have been merged into one byte stream. It takes bytes with start and end markers and rebuilds each packet. The 4-byte header is checked against its 6-bit error code. A single flipped bit is repaired before the length field is trusted. A header with two flipped bits is rejected, and the rest of that packet is dropped. The data type field decides what follows the header. A short packet is only the header. A long packet carries a payload of the counted length and then a 2-byte checksum.

The decoded header fields come out in one cycle, together with a pulse. Payload bytes leave on a byte stream with a last flag. The block holds each payload byte back by one byte, so that the checksum verdict can leave together with the final payload byte. Every packet that completes, or that is cut short by its end marker, gives one completion pulse that carries the checksum and length flags.

Top module: `pkt_rx_parser`

## Requirements
- R1: A byte with `in_valid` and `in_sop` high is header byte 0: bits [7:6] are the virtual channel and bits [5:0] are the data type. Byte 1 is the low half of the 16-bit count, byte 2 is the high half, and bits [5:0] of byte 3 are the check bits; bits [7:6] of byte 3 are ignored. The decoded fields appear with a one-cycle `hdr_valid` pulse in the cycle after byte 3 is accepted.
- R2: The check code covers d = {byte2, byte1, byte0} (24 bits). Data bit i gets the i-th value, in ascending order, of the 6-bit values whose weight is odd and at least 3. Check bit k is the XOR of every d[i] whose value has bit k set.
- R3: A header with no error raises neither flag. A header with exactly one flipped bit, in any of its 30 protected positions, is reported with correct fields and `hdr_fixed` high. `hdr_fixed` and `hdr_bad` are never high together.
- R4: A header whose syndrome is nonzero and cannot be matched to a single bit (this includes every two-bit error) raises `hdr_bad` and `pkt_done`. No payload is forwarded after it, and all bytes are ignored until the next start byte.
- R5: After error repair, a data type of 0x0F or less marks a short packet. `pkt_done` pulses together with `hdr_valid`, and bytes that follow without a start marker are ignored.
- R6: A long packet (data type 0x10 or more) forwards exactly `count` payload bytes, in order, on `out_byte`/`out_valid`. `out_last` marks the final byte and comes in the same cycle as `pkt_done`.
- R7: The checksum is CRC-16 with polynomial x^16+x^12+x^5+1, processed LSB first (reflected constant 0x8408), seed 0xFFFF and no final inversion. It is computed over the payload. The two bytes after the payload are the expected value, low byte first. On a mismatch, `crc_err` pulses together with `pkt_done`.
- R8: A long packet with a count of 0 forwards no payload and signals `pkt_done` after its two checksum bytes (expected value 0xFFFF).
- R9: An end marker that arrives before the header, payload and checksum are complete pulses `pkt_done` with `len_err`. `crc_err` stays low, no payload byte is forwarded in that cycle, and no `out_last` is given.
- R10: A start byte restarts the parser in any state. A partial packet that is abandoned this way produces no `pkt_done`.
- R11: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input byte is present |
| in_byte | input | 8 | Input byte |
| in_sop | input | 1 | Byte is the first of a packet |
| in_eop | input | 1 | Byte is the last of a packet |
| hdr_valid | output | 1 | Header fields below are new (pulse) |
| hdr_vc | output | 2 | Virtual channel |
| hdr_dt | output | 6 | Data type |
| hdr_wc | output | 16 | Payload byte count or short-packet value |
| hdr_long | output | 1 | Packet carries payload and checksum |
| hdr_fixed | output | 1 | A single header bit was repaired |
| hdr_bad | output | 1 | Header error could not be repaired |
| out_valid | output | 1 | Payload byte is present |
| out_byte | output | 8 | Payload byte |
| out_last | output | 1 | Final payload byte of the packet |
| pkt_done | output | 1 | Packet finished or was cut short (pulse) |
| crc_err | output | 1 | Payload checksum mismatch, valid with pkt_done |
| len_err | output | 1 | Packet ended early, valid with pkt_done |

## Verification
Every data type value from 0 to 63 is sent, with bytes trailing after the short ones. This shows whether the short/long split sits exactly between 0x0F and 0x10. All 30 single-bit header flips and all 435 two-bit flips are injected, which separates repair from rejection for every syndrome. A sweep of counts from 0 to 6, plus one long payload, checks payload order, the last-byte timing and the checksum. Corrupted checksums, end markers at three depths and an aborted header followed by a clean packet separate checksum failure, length failure and restart.

// File: rtl/pkt_rx_pkg.sv
// Shared constants, state type and header check-code helpers for the packet parser.
// Assumes an 8-bit byte stream and a 24-bit protected header with 6 check bits.
package pkt_rx_pkg;

    localparam int BYTE_W        = 8;
    localparam int WC_W          = 16;
    localparam int DT_W          = 6;
    localparam int VC_W          = 2;
    localparam int HDR_DATA_BITS = VC_W + DT_W + WC_W;
    localparam int ECC_BITS      = 6;
    localparam int ECC_CODES     = 1 << ECC_BITS;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HDR,
        ST_PLD,
        ST_FTR
    } rx_state_e;

    // Column code of data bit idx: idx-th ascending value with odd weight >= 3.
    function automatic logic [ECC_BITS-1:0] ecc_col(input int idx);
        int                  n;
        int                  w;
        logic [ECC_BITS-1:0] r;
        n = 0;
        r = '0;
        for (int v = 1; v < ECC_CODES; v++) begin
            w = $countones(ECC_BITS'(v));
            if ((w % 2 == 1) && (w >= 3)) begin
                if (n == idx) r = ECC_BITS'(v);
                n++;
            end
        end
        return r;
    endfunction

    // Mask of the data bits that feed check bit k.
    function automatic logic [HDR_DATA_BITS-1:0] ecc_mask(input int k);
        logic [HDR_DATA_BITS-1:0] m;
        logic [ECC_BITS-1:0]      c;
        m = '0;
        for (int i = 0; i < HDR_DATA_BITS; i++) begin
            c    = ecc_col(i);
            m[i] = c[k];
        end
        return m;
    endfunction

endpackage

// File: rtl/hdr_ecc_dec.sv
// Header check-code decoder: recomputes the check bits over the 24 header
// data bits, forms the syndrome, repairs a single flipped bit and flags
// syndromes that no single bit explains. Purely combinational.
// Assumes the column codes from pkt_rx_pkg::ecc_col.
module hdr_ecc_dec
    import pkt_rx_pkg::*;
(
    input  logic [HDR_DATA_BITS-1:0] data_in,
    input  logic [ECC_BITS-1:0]      ecc_in,
    output logic [HDR_DATA_BITS-1:0] data_out,
    output logic                     corrected,
    output logic                     uncorrectable
);

    logic [ECC_BITS-1:0]      parity;
    logic [ECC_BITS-1:0]      syndrome;
    logic [HDR_DATA_BITS-1:0] flip;
    logic                     hit_data;
    logic                     hit_check;

    // One parity tree per check bit.
    for (genvar k = 0; k < ECC_BITS; k++) begin : g_par
        localparam logic [HDR_DATA_BITS-1:0] MASK = ecc_mask(k);
        assign parity[k] = ^(data_in & MASK);
    end

    assign syndrome = parity ^ ecc_in;

    // One comparator per data bit, matching the syndrome against its column.
    for (genvar i = 0; i < HDR_DATA_BITS; i++) begin : g_flip
        localparam logic [ECC_BITS-1:0] COL = ecc_col(i);
        assign flip[i] = (syndrome == COL);
    end

    // Classify the syndrome: data-bit hit, check-bit hit (weight 1) or neither.
    always_comb begin
        hit_data      = |flip;
        hit_check     = (syndrome != '0) && ((syndrome & (syndrome - 1'b1)) == '0);
        data_out      = data_in ^ flip;
        corrected     = hit_data || hit_check;
        uncorrectable = (syndrome != '0) && !hit_data && !hit_check;
    end

endmodule

// File: rtl/crc16_byte_step.sv
// One byte step of a reflected CRC-16: shifts the eight bits of data_in, LSB
// first, through the register crc_in. Purely combinational.
// Assumes a reflected polynomial constant (bit 0 holds the x^15 term).
module crc16_byte_step #(
    parameter int               CRC_W  = 16,
    parameter int               DATA_W = 8,
    parameter logic [CRC_W-1:0] POLY   = 16'h8408
) (
    input  logic [CRC_W-1:0]  crc_in,
    input  logic [DATA_W-1:0] data_in,
    output logic [CRC_W-1:0]  crc_out
);

    // Bit-serial update unrolled over the byte.
    always_comb begin
        logic [CRC_W-1:0] c;
        c = crc_in;
        for (int b = 0; b < DATA_W; b++) begin
            if (c[0] ^ data_in[b]) c = (c >> 1) ^ POLY;
            else                   c = c >> 1;
        end
        crc_out = c;
    end

endmodule

// File: rtl/pkt_rx_parser.sv
// Receive-side packet parser. It rebuilds packets from a byte stream with
// start/end markers, repairs or rejects the 4-byte header, sorts short from
// long packets by data type, forwards the payload with a one-byte hold so that
// the checksum verdict rides on the final byte, and flags early ends.
// Assumes that a start byte always begins a new packet and that bytes without
// a start marker after a packet is finished are idle traffic.
module pkt_rx_parser
    import pkt_rx_pkg::*;
#(
    parameter logic [DT_W-1:0] SHORT_DT_MAX = 6'h0F,
    parameter logic [15:0]     CRC_SEED     = 16'hFFFF,
    parameter logic [15:0]     CRC_POLY     = 16'h8408
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic              in_sop,
    input  logic              in_eop,
    output logic              hdr_valid,
    output logic [VC_W-1:0]   hdr_vc,
    output logic [DT_W-1:0]   hdr_dt,
    output logic [WC_W-1:0]   hdr_wc,
    output logic              hdr_long,
    output logic              hdr_fixed,
    output logic              hdr_bad,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_byte,
    output logic              out_last,
    output logic              pkt_done,
    output logic              crc_err,
    output logic              len_err
);

    localparam int CRC_W = 16;

    rx_state_e                st;
    logic [1:0]               hidx;
    logic [BYTE_W-1:0]        hb0;
    logic [BYTE_W-1:0]        hb1;
    logic [BYTE_W-1:0]        hb2;
    logic [WC_W-1:0]          remain;
    logic [CRC_W-1:0]         crc_q;
    logic [CRC_W-1:0]         crc_nx;
    logic [BYTE_W-1:0]        held;
    logic                     held_v;
    logic [BYTE_W-1:0]        foot_lo;
    logic                     fidx;

    logic [HDR_DATA_BITS-1:0] dec_word;
    logic                     dec_fix;
    logic                     dec_bad;
    logic [DT_W-1:0]          dec_dt;
    logic [VC_W-1:0]          dec_vc;
    logic [WC_W-1:0]          dec_wc;
    logic                     dec_long;

    hdr_ecc_dec i_ecc (
        .data_in       ({hb2, hb1, hb0}),
        .ecc_in        (in_byte[ECC_BITS-1:0]),
        .data_out      (dec_word),
        .corrected     (dec_fix),
        .uncorrectable (dec_bad)
    );

    crc16_byte_step #(
        .CRC_W  (CRC_W),
        .DATA_W (BYTE_W),
        .POLY   (CRC_POLY)
    ) i_crc (
        .crc_in  (crc_q),
        .data_in (in_byte),
        .crc_out (crc_nx)
    );

    // Split the repaired header word into its fields.
    always_comb begin
        dec_dt   = dec_word[DT_W-1:0];
        dec_vc   = dec_word[DT_W+VC_W-1:DT_W];
        dec_wc   = dec_word[HDR_DATA_BITS-1:DT_W+VC_W];
        dec_long = (dec_dt > SHORT_DT_MAX);
    end

    // Packet state machine, header capture, payload hold stage and status pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            hidx      <= '0;
            hb0       <= '0;
            hb1       <= '0;
            hb2       <= '0;
            remain    <= '0;
            crc_q     <= CRC_SEED;
            held      <= '0;
            held_v    <= 1'b0;
            foot_lo   <= '0;
            fidx      <= 1'b0;
            hdr_valid <= 1'b0;
            hdr_vc    <= '0;
            hdr_dt    <= '0;
            hdr_wc    <= '0;
            hdr_long  <= 1'b0;
            hdr_fixed <= 1'b0;
            hdr_bad   <= 1'b0;
            out_valid <= 1'b0;
            out_byte  <= '0;
            out_last  <= 1'b0;
            pkt_done  <= 1'b0;
            crc_err   <= 1'b0;
            len_err   <= 1'b0;
        end else begin
            hdr_valid <= 1'b0;
            out_valid <= 1'b0;
            out_last  <= 1'b0;
            pkt_done  <= 1'b0;
            crc_err   <= 1'b0;
            len_err   <= 1'b0;
            if (in_valid && in_sop) begin
                hb0    <= in_byte;
                hidx   <= 2'd1;
                held_v <= 1'b0;
                if (in_eop) begin
                    pkt_done <= 1'b1;
                    len_err  <= 1'b1;
                    st       <= ST_IDLE;
                end else begin
                    st <= ST_HDR;
                end
            end else if (in_valid) begin
                unique case (st)
                    ST_HDR: begin
                        if (hidx != 2'd3) begin
                            if (hidx == 2'd1) hb1 <= in_byte;
                            else              hb2 <= in_byte;
                            hidx <= hidx + 2'd1;
                            if (in_eop) begin
                                pkt_done <= 1'b1;
                                len_err  <= 1'b1;
                                st       <= ST_IDLE;
                            end
                        end else begin
                            hdr_valid <= 1'b1;
                            hdr_fixed <= dec_fix;
                            hdr_bad   <= dec_bad;
                            hdr_vc    <= dec_vc;
                            hdr_dt    <= dec_dt;
                            hdr_wc    <= dec_wc;
                            hdr_long  <= dec_long && !dec_bad;
                            crc_q     <= CRC_SEED;
                            remain    <= dec_wc;
                            fidx      <= 1'b0;
                            if (dec_bad || !dec_long) begin
                                pkt_done <= 1'b1;
                                st       <= ST_IDLE;
                            end else if (in_eop) begin
                                pkt_done <= 1'b1;
                                len_err  <= 1'b1;
                                st       <= ST_IDLE;
                            end else if (dec_wc == '0) begin
                                st <= ST_FTR;
                            end else begin
                                st <= ST_PLD;
                            end
                        end
                    end
                    ST_PLD: begin
                        if (in_eop) begin
                            pkt_done <= 1'b1;
                            len_err  <= 1'b1;
                            held_v   <= 1'b0;
                            st       <= ST_IDLE;
                        end else begin
                            crc_q     <= crc_nx;
                            out_valid <= held_v;
                            out_byte  <= held;
                            held      <= in_byte;
                            held_v    <= 1'b1;
                            remain    <= remain - 1'b1;
                            if (remain == WC_W'(1)) st <= ST_FTR;
                        end
                    end
                    ST_FTR: begin
                        if (!fidx) begin
                            foot_lo <= in_byte;
                            fidx    <= 1'b1;
                            if (in_eop) begin
                                pkt_done <= 1'b1;
                                len_err  <= 1'b1;
                                held_v   <= 1'b0;
                                st       <= ST_IDLE;
                            end
                        end else begin
                            pkt_done  <= 1'b1;
                            crc_err   <= ({in_byte, foot_lo} != crc_q);
                            out_valid <= held_v;
                            out_last  <= held_v;
                            out_byte  <= held;
                            held_v    <= 1'b0;
                            st        <= ST_IDLE;
                        end
                    end
                    default: begin
                        st <= ST_IDLE;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/pkt_rx_parser_chk.sv
// Property checker for pkt_rx_parser, attached by bind. It watches only ports
// and keeps one flag of its own for the discard window after a rejected header.
module pkt_rx_parser_chk
    import pkt_rx_pkg::*;
#(
    parameter logic [DT_W-1:0] SHORT_DT_MAX = 6'h0F
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic            in_sop,
    input logic            hdr_valid,
    input logic [DT_W-1:0] hdr_dt,
    input logic            hdr_fixed,
    input logic            hdr_bad,
    input logic            out_valid,
    input logic            out_last,
    input logic            pkt_done,
    input logic            crc_err,
    input logic            len_err
);

    logic discard_q;

    // Open the discard window on a rejected header, close it on a start byte.
    always_ff @(posedge clk) begin
        if (!rst_n)                    discard_q <= 1'b0;
        else if (in_valid && in_sop)   discard_q <= 1'b0;
        else if (hdr_valid && hdr_bad) discard_q <= 1'b1;
    end

    a_r3_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid |-> !(hdr_fixed && hdr_bad));

    a_r4_no_payload_after_bad: assert property (@(posedge clk) disable iff (!rst_n)
        discard_q |-> !out_valid);

    a_r4_bad_ends_packet: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && hdr_bad) |-> pkt_done);

    a_r5_short_done_with_header: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && !hdr_bad && (hdr_dt <= SHORT_DT_MAX)) |-> pkt_done);

    a_r6_last_is_data: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> (out_valid && pkt_done));

    a_r7_crc_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        crc_err |-> (pkt_done && !len_err));

    a_r9_len_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        len_err |-> (pkt_done && !out_valid && !out_last));

endmodule

bind pkt_rx_parser pkt_rx_parser_chk #(
    .SHORT_DT_MAX (SHORT_DT_MAX)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_sop    (in_sop),
    .hdr_valid (hdr_valid),
    .hdr_dt    (hdr_dt),
    .hdr_fixed (hdr_fixed),
    .hdr_bad   (hdr_bad),
    .out_valid (out_valid),
    .out_last  (out_last),
    .pkt_done  (pkt_done),
    .crc_err   (crc_err),
    .len_err   (len_err)
);

// File: tb/test_pkt_rx_parser.sv
`timescale 1ns/1ps
module test_pkt_rx_parser;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = 8'h00;
    logic        in_sop = 1'b0;
    logic        in_eop = 1'b0;
    logic        hdr_valid;
    logic [1:0]  hdr_vc;
    logic [5:0]  hdr_dt;
    logic [15:0] hdr_wc;
    logic        hdr_long;
    logic        hdr_fixed;
    logic        hdr_bad;
    logic        out_valid;
    logic [7:0]  out_byte;
    logic        out_last;
    logic        pkt_done;
    logic        crc_err;
    logic        len_err;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    pkt_rx_parser i_pkt_rx_parser (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .in_sop(in_sop), .in_eop(in_eop), .hdr_valid(hdr_valid), .hdr_vc(hdr_vc),
        .hdr_dt(hdr_dt), .hdr_wc(hdr_wc), .hdr_long(hdr_long), .hdr_fixed(hdr_fixed),
        .hdr_bad(hdr_bad), .out_valid(out_valid), .out_byte(out_byte),
        .out_last(out_last), .pkt_done(pkt_done), .crc_err(crc_err), .len_err(len_err)
    );

    // Monitor state, sampled at the falling edge.
    logic [7:0]  got [0:1023];
    int          got_n, last_n, last_pos, hv_n, done_n;
    bit          last_with_done, f_crc, f_len;
    logic [1:0]  c_vc;
    logic [5:0]  c_dt;
    logic [15:0] c_wc;
    bit          c_long, c_fix, c_bad;

    always @(negedge clk) begin
        if (hdr_valid) begin
            hv_n++;
            c_vc = hdr_vc; c_dt = hdr_dt; c_wc = hdr_wc;
            c_long = hdr_long; c_fix = hdr_fixed; c_bad = hdr_bad;
        end
        if (pkt_done) begin
            done_n++;
            f_crc = f_crc | crc_err;
            f_len = f_len | len_err;
        end
        if (out_valid) begin
            if (out_last) begin
                last_n++;
                last_pos = got_n;
                last_with_done = pkt_done;
            end
            got[got_n] = out_byte;
            got_n++;
        end
    end

    task automatic clr();
        got_n = 0; last_n = 0; last_pos = -1; hv_n = 0; done_n = 0;
        last_with_done = 0; f_crc = 0; f_len = 0; c_bad = 0; c_fix = 0;
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Column code from the check-code rule: ascending odd-weight values, weight >= 3.
    function automatic logic [5:0] col_of(input int idx);
        int n = 0;
        for (int v = 1; v < 64; v++) begin
            int w = $countones(6'(v));
            if ((w % 2 == 1) && (w >= 3)) begin
                if (n == idx) return 6'(v);
                n++;
            end
        end
        return 6'd0;
    endfunction

    function automatic logic [5:0] ecc_of(input logic [23:0] d);
        logic [5:0] e = 6'd0;
        for (int i = 0; i < 24; i++) if (d[i]) e = e ^ col_of(i);
        return e;
    endfunction

    function automatic logic [15:0] crc_upd(input logic [15:0] c, input logic [7:0] b);
        for (int k = 0; k < 8; k++) begin
            if (c[0] ^ b[k]) c = (c >> 1) ^ 16'h8408;
            else             c = c >> 1;
        end
        return c;
    endfunction

    function automatic logic [7:0] pbyte(input int seed, input int i);
        return 8'(seed * 37 + i * 11 + 5);
    endfunction

    task automatic drv(input logic [7:0] b, input bit s, input bit e);
        @(negedge clk);
        in_valid = 1'b1; in_byte = b; in_sop = s; in_eop = e;
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // Build, send and check one packet. flips: bits 0..23 header data, 24..29 check bits.
    task automatic do_case(input int vc, input int dt, input int wc, input int seed,
                           input logic [29:0] flips, input bit bad_crc,
                           input int cut_at, input int pre_junk, input string req);
        logic [7:0]  pk [0:1023];
        int          n = 0;
        logic [23:0] d;
        logic [5:0]  e;
        logic [15:0] c = 16'hFFFF;
        bit          is_long = (dt > 15);
        int          nfl = $countones(flips);
        bit          exp_bad = (nfl == 2);
        bit          exp_fix = (nfl == 1);
        bit          exp_len = (cut_at >= 0);
        bit          exp_pay = is_long && !exp_bad && !exp_len;
        bit          exp_crc = bad_crc && exp_pay;
        int          exp_hv = (cut_at < 0 || cut_at >= 3) ? 1 : 0;
        d = {16'(wc), 2'(vc), 6'(dt)};
        e = ecc_of(d);
        d = d ^ flips[23:0];
        e = e ^ flips[29:24];
        pk[0] = d[7:0]; pk[1] = d[15:8]; pk[2] = d[23:16]; pk[3] = {2'b10, e};
        n = 4;
        if (is_long) begin
            for (int i = 0; i < wc; i++) begin
                pk[n] = pbyte(seed, i);
                c = crc_upd(c, pk[n]);
                n++;
            end
            pk[n] = c[7:0] ^ {7'd0, bad_crc}; n++;
            pk[n] = c[15:8]; n++;
        end else begin
            for (int i = 0; i < 3; i++) begin pk[n] = pbyte(seed, i); n++; end
        end
        idle(2);
        clr();
        for (int j = 0; j < pre_junk; j++) drv(8'h30 + 8'(j), j == 0, 1'b0);
        for (int j = 0; j < n; j++) begin
            if (cut_at >= 0 && j > cut_at) break;
            drv(pk[j], j == 0, (j == n - 1) || (j == cut_at));
        end
        idle(4);
        chk(done_n == 1, req, "pkt_done count", done_n, 1);
        chk(hv_n == exp_hv, req, "hdr_valid count", hv_n, exp_hv);
        if (exp_hv == 1) begin
            chk(c_bad == exp_bad, req, "hdr_bad", c_bad, exp_bad);
            chk(c_fix == exp_fix, req, "hdr_fixed", c_fix, exp_fix);
            if (!exp_bad) begin
                chk(c_vc == 2'(vc), req, "vc", c_vc, vc);
                chk(c_dt == 6'(dt), req, "dt", c_dt, dt);
                chk(c_wc == 16'(wc), req, "wc", c_wc, wc);
                chk(c_long == is_long, req, "long", c_long, is_long);
            end
        end
        chk(f_len == exp_len, req, "len_err", f_len, exp_len);
        chk(f_crc == exp_crc, req, "crc_err", f_crc, exp_crc);
        if (exp_pay) begin
            chk(got_n == wc, req, "payload count", got_n, wc);
            for (int i = 0; i < wc && i < got_n; i++)
                chk(got[i] == pbyte(seed, i), req, "payload byte", got[i], pbyte(seed, i));
            chk(last_n == ((wc > 0) ? 1 : 0), req, "last count", last_n, (wc > 0) ? 1 : 0);
            if (wc > 0) begin
                chk(last_pos == wc - 1, req, "last position", last_pos, wc - 1);
                chk(last_with_done, req, "last with done", last_with_done, 1);
            end
        end else if (exp_len) begin
            chk(last_n == 0, req, "no last on early end", last_n, 0);
        end else begin
            chk(got_n == 0, req, "no payload forwarded", got_n, 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog timeout actual=1 expected=0");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state of every output.
        chk({hdr_valid, hdr_vc, hdr_dt, hdr_wc, hdr_long, hdr_fixed, hdr_bad} == '0,
            "R11", "header outputs", 0, 0);
        chk({out_valid, out_byte, out_last, pkt_done, crc_err, len_err} == '0,
            "R11", "stream outputs", 0, 0);
        rst_n = 1'b1;
        // R1, R5, R6: every data type, short ones followed by stray bytes.
        for (int dt = 0; dt < 64; dt++)
            do_case(dt % 4, dt, (dt > 15) ? 3 : dt * 257, dt, 30'd0, 1'b0, -1, 0, "R5");
        // R6, R7, R8: count sweep and one long payload.
        for (int wc = 0; wc <= 6; wc++)
            do_case(1, 6'h2A, wc, wc + 7, 30'd0, 1'b0, -1, 0, "R8");
        do_case(2, 6'h3F, 300, 9, 30'd0, 1'b0, -1, 0, "R6");
        // R2, R3: every single-bit flip.
        for (int k = 0; k < 30; k++)
            do_case(3, 6'h2B, 4, k, 30'd1 << k, 1'b0, -1, 0, "R3");
        // R4: every two-bit flip.
        for (int a = 0; a < 30; a++)
            for (int b = a + 1; b < 30; b++)
                do_case(1, 6'h24, 3, a, (30'd1 << a) | (30'd1 << b), 1'b0, -1, 0, "R4");
        // R7: corrupted checksum.
        do_case(0, 6'h12, 1, 3, 30'd0, 1'b1, -1, 0, "R7");
        do_case(0, 6'h12, 5, 4, 30'd0, 1'b1, -1, 0, "R7");
        do_case(0, 6'h12, 0, 5, 30'd0, 1'b1, -1, 0, "R7");
        // R9: end marker in header, payload and first checksum byte.
        do_case(1, 6'h22, 8, 6, 30'd0, 1'b0, 1, 0, "R9");
        do_case(1, 6'h22, 8, 6, 30'd0, 1'b0, 6, 0, "R9");
        do_case(1, 6'h22, 8, 6, 30'd0, 1'b0, 12, 0, "R9");
        // R10: aborted header then a clean packet.
        do_case(2, 6'h1C, 5, 8, 30'd0, 1'b0, -1, 2, "R10");
        do_case(2, 6'h05, 0, 8, 30'd0, 1'b0, -1, 3, "R10");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule